// File: doc/BRIEF.md
# Odd-Multiple Constant Multiplier with Anti-Symmetric Coding

This block multiplies an unsigned 5-bit operand by a coefficient fixed at elaboration time. It does not use an array multiplier. Each result is formed as sixteen times the coefficient, plus or minus a short code word. The code word comes from a table of nine constants: the eight odd multiples of the coefficient from 1 to 15, plus twice the coefficient. A two-stage left shifter then rebuilds any even multiple from its odd part. The code word for operand 10000 is zero. The table output is gated off for that operand instead of storing a zero word.

Operands enter on a valid/ready stream and products leave on a second valid/ready stream. When the output register is enabled, a transfer happens on each rising edge where valid and ready are both high. A result that is not accepted stays on the output unchanged until the consumer raises ready. The input stays ready whenever the output register is empty or is being drained in the same cycle, so full throughput is kept. When the output register is disabled, the product is combinational, `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

Top module: `oddmul_const_mult`

## Requirements
- R1: Every accepted operand x in 0..31 yields `out_prod` equal to COEF*x, exactly, in W+5 bits.
- R2: When x[4] is 1 and x[3:0] is nonzero, the code index is x[3:0] and the product is 16*COEF plus the code word.
- R3: When x[4] is 0 and x[3:0] is nonzero, the code index is 16 minus x[3:0] and the product is 16*COEF minus the code word. The subtraction never goes below zero.
- R4: For x = 10000 the code word is zero. This is obtained by driving no table select at all, and the product equals 16*COEF.
- R5: For x = 00000 the table address is 8, the word that holds 2*COEF, and the shift amount is 3. The code word is therefore 16*COEF and the product is 0.
- R6: For a nonzero code index k, the shift amount is the number of trailing zeros of k. The table address is the odd part of k shifted right by one. Shifting never drops a set bit.
- R7: With the largest coefficient, 2^W-1, all 32 products come out exact, with no overflow of the table words or the sum.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_prod` holds its value on the next cycle.
- R9: During reset `out_valid` is 0. Products leave in the same order as operands were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present on `in_x` |
| in_ready | output | 1 | Block can take an operand this cycle |
| in_x | input | 5 | Unsigned operand |
| out_valid | output | 1 | Product present on `out_prod` |
| out_ready | input | 1 | Consumer takes the product this cycle |
| out_prod | output | W+5 | COEF times the operand |

## Verification
The bench builds four copies of the block side by side, all fed from one operand stream:
- W=7 with coefficient 93, an irregular bit pattern that exercises every table word.
- W=4 with coefficient 1, where the table words equal their own multipliers.
- W=4 with coefficient 15, the largest value, which drives the 31*A sum to the top of its width.
- W=4 with coefficient 8, a power of two whose odd multiples all end in zeros.

Each copy sweeps all 32 operands twice: once with the consumer always ready, and once with pseudo-random back-pressure. This covers the add path, the subtract path, both zero-index cases and every shift amount, and it also exercises stall holding.

// File: rtl/oddmul_pkg.sv
package oddmul_pkg;
  localparam int IN_W   = 5;
  localparam int IDX_W  = IN_W - 1;
  localparam int NWORDS = (1 << (IDX_W - 1)) + 1;
  localparam int ADDR_W = IDX_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [1:0]        shamt;
    logic              zap;
  } lut_ctl_t;
endpackage

// File: rtl/oddmul_addr_gen.sv
module oddmul_addr_gen
  import oddmul_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IN_W-1:0] x,
  output lut_ctl_t        ctl
);
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] odd;
  logic [1:0]       tz;

  assign idx = x[IN_W-1] ? x[IDX_W-1:0] : IDX_W'(0) - x[IDX_W-1:0];

  always_comb begin
    if (idx[0])      tz = 2'd0;
    else if (idx[1]) tz = 2'd1;
    else if (idx[2]) tz = 2'd2;
    else             tz = 2'd3;
    odd     = idx >> tz;
    ctl.zap = x[IN_W-1] & ~(|x[IDX_W-1:0]);
    if (idx == '0) begin
      ctl.addr  = ADDR_W'(NWORDS - 1);
      ctl.shamt = 2'd3;
    end else begin
      ctl.addr  = {1'b0, odd[IDX_W-1:1]};
      ctl.shamt = tz;
    end
  end

  logic [IN_W-1:0] rebuilt;
  assign rebuilt = IN_W'({ctl.addr[ADDR_W-2:0], 1'b1}) << ctl.shamt;

  AST_ADDR_REBUILDS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.zap && !ctl.addr[ADDR_W-1]) |-> (rebuilt == {1'b0, idx})); // R6
  AST_ZERO_OPERAND_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    (x == '0) |-> (ctl.addr == ADDR_W'(NWORDS - 1) && ctl.shamt == 2'd3 && !ctl.zap)); // R5
endmodule

// File: rtl/oddmul_table.sv
module oddmul_table
  import oddmul_pkg::*;
#(
  parameter int           W    = 8,
  parameter logic [W-1:0] COEF = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  output logic [W+3:0]      word
);
  logic [NWORDS-1:0] sel;
  logic [W+3:0]      rom [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    if (g < NWORDS - 1) begin : g_odd
      assign sel[g] = en & ~addr[ADDR_W-1] & (addr[ADDR_W-2:0] == (ADDR_W-1)'(g));
      assign rom[g] = (W+4)'(COEF) * (W+4)'(2 * g + 1);
    end else begin : g_two
      assign sel[g] = en & addr[ADDR_W-1];
      assign rom[g] = (W+4)'(COEF) << 1;
    end
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < NWORDS; i++) word |= rom[i] & {(W+4){sel[i]}};
  end

  AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ($countones(sel) == 1)); // R6
  AST_ZAP_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (sel == '0 && word == '0)); // R4
endmodule

// File: rtl/oddmul_shl.sv
module oddmul_shl #(
  parameter int IW = 12,
  parameter int OW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] din,
  input  logic [1:0]    shamt,
  output logic [OW-1:0] dout
);
  logic [OW-1:0] ext;
  logic [OW-1:0] st1;

  assign ext  = OW'(din);
  assign st1  = shamt[0] ? (ext << 1) : ext;
  assign dout = shamt[1] ? (st1 << 2) : st1;

  AST_SHIFT_LOSSLESS: assert property (@(posedge clk) disable iff (!rst_n)
    ((dout >> shamt) == ext)); // R6
endmodule

// File: rtl/oddmul_const_mult.sv
module oddmul_const_mult
  import oddmul_pkg::*;
#(
  parameter int           W       = 8,
  parameter logic [W-1:0] COEF    = 8'd181,
  parameter bit           REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IN_W-1:0] in_x,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W+4:0]    out_prod
);
  localparam int PW = W + IN_W;

  lut_ctl_t      ctl;
  logic [W+3:0]  word;
  logic [PW-1:0] code;
  logic [PW-1:0] base;
  logic [PW-1:0] prod_c;

  oddmul_addr_gen u_addr (.clk(clk), .rst_n(rst_n), .x(in_x), .ctl(ctl));

  oddmul_table #(.W(W), .COEF(COEF)) u_tab (
    .clk(clk), .rst_n(rst_n), .addr(ctl.addr), .en(!ctl.zap), .word(word));

  oddmul_shl #(.IW(W + 4), .OW(PW)) u_shl (
    .clk(clk), .rst_n(rst_n), .din(word), .shamt(ctl.shamt), .dout(code));

  assign base   = PW'({COEF, 4'b0000});
  assign prod_c = in_x[IN_W-1] ? (base + code) : (base - code);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_x[IN_W-1]) |-> (code <= base)); // R3
  AST_PROD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (prod_c == PW'(COEF) * PW'(in_x))); // R1

  if (REG_OUT) begin : g_reg
    logic          vld_q;
    logic [PW-1:0] prod_q;
    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign out_prod  = prod_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        prod_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) prod_q <= prod_c;
      end
    end
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_prod))); // R8
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_prod  = prod_c;
  end
endmodule

// File: tb/oddmul_const_mult_bench.sv
module oddmul_const_mult_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [4:0] in_x = '0;
  logic out_ready = 1'b1;
  logic stall_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int n_chk = 0;
  int n_bad = 0;
  logic [4:0] exp_q[$];

  always #10 clk = ~clk;

  logic rdy0, rdy1, rdy2, rdy3;
  logic ov0, ov1, ov2, ov3;
  logic [11:0] p0;
  logic [8:0]  p1, p2, p3;

  oddmul_const_mult #(.W(7), .COEF(7'd93)) u_oddmul_const_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy0), .in_x(in_x),
    .out_valid(ov0), .out_ready(out_ready), .out_prod(p0));
  oddmul_const_mult #(.W(4), .COEF(4'd1)) u_a1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy1), .in_x(in_x),
    .out_valid(ov1), .out_ready(out_ready), .out_prod(p1));
  oddmul_const_mult #(.W(4), .COEF(4'd15)) u_amax (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy2), .in_x(in_x),
    .out_valid(ov2), .out_ready(out_ready), .out_prod(p2));
  oddmul_const_mult #(.W(4), .COEF(4'd8)) u_apow2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy3), .in_x(in_x),
    .out_valid(ov3), .out_ready(out_ready), .out_prod(p3));

  function automatic string tag_of(input logic [4:0] x);
    if (x == 5'd0)        return "R5";
    if (x == 5'd16)       return "R4";
    if (!x[0])            return "R6";
    if (x[4])             return "R2";
    return "R3";
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // pseudo-random consumer ready, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= stall_mode ? lfsr[3] : 1'b1;
  end

  // reset state, R9
  initial begin
    repeat (3) begin
      @(negedge clk);
      chk("R9", "out_valid in reset", int'({ov0, ov1, ov2, ov3}), 0);
    end
  end

  // monitor: scoreboard compare and stall holding
  logic held = 1'b0;
  logic [11:0] held_p;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        chk("R8", "valid held under stall", int'(ov0), 1);
        chk("R8", "product held under stall", int'(p0), int'(held_p));
      end
      if (ov0 && out_ready) begin
        if (exp_q.size() == 0) begin
          chk("R9", "unexpected output", 1, 0);
        end else begin
          logic [4:0] x;
          x = exp_q.pop_front();
          chk({"R1/", tag_of(x)}, $sformatf("A=93 x=%0d", x), int'(p0), 93 * int'(x));
          chk({"R1/", tag_of(x)}, $sformatf("A=1 x=%0d", x), int'(p1), int'(x));
          chk("R7", $sformatf("A=15 x=%0d", x), int'(p2), 15 * int'(x));
          chk({"R1/", tag_of(x)}, $sformatf("A=8 x=%0d", x), int'(p3), 8 * int'(x));
          chk("R9", "valid lockstep", int'({ov1, ov2, ov3}), 7);
        end
      end
      held   <= ov0 && !out_ready;
      held_p <= p0;
    end
  end

  task automatic send(input logic [4:0] x);
    in_valid = 1'b1;
    in_x     = x;
    forever begin
      @(negedge clk);
      if (rdy0) break;
    end
    exp_q.push_back(x);
    @(posedge clk);
    #2;
    in_valid = 1'b0;
  endtask

  logic done = 1'b0;
  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk);
    #2;
    for (int i = 0; i < 32; i++) send(5'(i));
    stall_mode = 1'b1;
    for (int i = 31; i >= 0; i--) send(5'(i));
    for (int i = 0; i < 500 && exp_q.size() != 0; i++) @(posedge clk);
    chk("R9", "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule